// File: doc/BRIEF.md
# Redundant User Permit Combiner

This block merges the permits of up to twenty users into one permit per beam. Every user drives two redundant permit lines, A and B. The block handles them in two identical, separate logic paths. On each path it judges every input against the beam or beams that the input serves. A beam keeps its permit only while both paths agree that every relevant user permits it.

The inputs are grouped by position. The lowest group serves beam 1 only. The middle group serves both beams, so a withdrawal there drops both beams together. The top group serves beam 2 only.

Selected inputs can be masked, but only while a redundant safe-beam flag reads safe on both of its copies. If the two copies disagree, or if both read unsafe, every mask is ignored. The raw A and B levels of the inputs are exposed per beam for diagnostic readout.

Top module: `permit_combiner`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `beam1Permit` and `beam2Permit` are 0 and all four state vectors are 0.
- R2: When every input mapped to a beam is 1 on both `permitA` and `permitB`, that beam's permit is 1 one clock edge later.
- R3: A single unmasked input mapped to a beam that is 0 on only its A line, or on only its B line, drives that beam's permit to 0 after the next clock edge.
- R4: The inputs at indices NUM_B1 to NUM_B1+NUM_BOTH-1 (6 to 13 by default) serve both beams. A 0 on one of them, when unmasked, clears both permits.
- R5: Inputs 0 to NUM_B1-1 (0 to 5) affect only `beam1Permit`. Inputs from NUM_B1+NUM_BOTH upward (14 to 19) affect only `beam2Permit`.
- R6: When `safeFlagA` and `safeFlagB` are both 1, an input whose `maskCfg` bit is 1 is ignored on both paths. A mask bit on one input has no effect on any other input.
- R7: When `safeFlagA` and `safeFlagB` differ, or are both 0, all `maskCfg` bits are ignored.
- R8: The state vectors are registered copies of the raw input levels, with no masking applied. For beam 1, bit k holds input k (bits 0 to 13). For beam 2, bit k holds input NUM_B1+k, so bits 0 to 7 hold the both-beam inputs and bits 8 to 13 hold the beam-2-only inputs. The A vectors come from `permitA` and the B vectors from `permitB`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| permitA | input | NUM_IN (20) | A-line permit of each user, 1 = permit |
| permitB | input | NUM_IN (20) | B-line permit of each user, 1 = permit |
| maskCfg | input | NUM_IN (20) | Per-input mask request, 1 = mask |
| safeFlagA | input | 1 | Safe-beam flag, copy A |
| safeFlagB | input | 1 | Safe-beam flag, copy B |
| beam1Permit | output | 1 | Local permit for beam 1 |
| beam2Permit | output | 1 | Local permit for beam 2 |
| stateA1 | output | NUM_B1+NUM_BOTH (14) | A-line levels of the beam-1 inputs |
| stateB1 | output | NUM_B1+NUM_BOTH (14) | B-line levels of the beam-1 inputs |
| stateA2 | output | NUM_BOTH+NUM_B2 (14) | A-line levels of the beam-2 inputs |
| stateB2 | output | NUM_BOTH+NUM_B2 (14) | B-line levels of the beam-2 inputs |

## Verification
The assertions check these properties on every cycle:
- A granted beam with masking off always shows all-ones state vectors.
- Beam 2 follows the inputs it serves, whatever the beam-1-only lines do.
- A low both-beam input with masking off clears both beams.
- A disagreeing safe flag never lets a low input through.

The bench scenarios cover what a single-cycle property cannot show:
- that the mask on one input leaves its neighbours unaffected;
- that either copy of the flag alone disables masking;
- the exact bit layout of the diagnostic vectors;
- the one-edge latency of a withdrawal;
- the reset values.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef struct packed {
    logic maskOn;        // masks may be honoured
    logic flagMismatch;  // the two flag copies disagree
  } ctlStrobe_t;
endpackage

// File: rtl/pc_ctrl.sv
module pc_ctrl
  import pc_pkg::*;
(
  input  logic       safeFlagA,
  input  logic       safeFlagB,
  output ctlStrobe_t strobe
);
  // Fail-safe: masking only when both copies positively read safe
  always_comb begin
    strobe.maskOn       = safeFlagA & safeFlagB;
    strobe.flagMismatch = safeFlagA ^ safeFlagB;
  end
endmodule

// File: rtl/pc_path.sv
module pc_path
  import pc_pkg::*;
#(
  parameter int NUM_B1   = 6,
  parameter int NUM_BOTH = 8,
  parameter int NUM_B2   = 6,
  localparam int NUM_IN  = NUM_B1 + NUM_BOTH + NUM_B2,
  localparam int W1      = NUM_B1 + NUM_BOTH,
  localparam int W2      = NUM_BOTH + NUM_B2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] perm,
  input  logic [NUM_IN-1:0] maskCfg,
  input  ctlStrobe_t        strobe,
  output logic              okBeam1,
  output logic              okBeam2,
  output logic [W1-1:0]     state1,
  output logic [W2-1:0]     state2
);
  logic [NUM_IN-1:0] inBeam1, inBeam2, passVec;
  logic ok1Next, ok2Next;

  // Fixed assignment of inputs to beams by position
  for (genvar i = 0; i < NUM_IN; i++) begin : g_map
    assign inBeam1[i] = (i < W1);
    assign inBeam2[i] = (i >= NUM_B1);
  end

  assign passVec = perm | (maskCfg & {NUM_IN{strobe.maskOn}});
  assign ok1Next = &(passVec | ~inBeam1);
  assign ok2Next = &(passVec | ~inBeam2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      okBeam1 <= 1'b0;
      okBeam2 <= 1'b0;
      state1  <= '0;
      state2  <= '0;
    end else begin
      okBeam1 <= ok1Next;
      okBeam2 <= ok2Next;
      state1  <= perm[W1-1:0];
      state2  <= perm[NUM_IN-1:NUM_B1];
    end
  end

  // R4: an unmasked low both-beam input clears both beams
  a_r4_both_withdraw: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!strobe.maskOn) && $past(!perm[NUM_B1])) |-> (!okBeam1 && !okBeam2));

  // R7: a disagreeing flag never lets a low beam-1 input through
  a_r7_mismatch_no_mask: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.flagMismatch) && $past(!perm[0])) |-> !okBeam1);
endmodule

// File: rtl/permit_combiner.sv
module permit_combiner
  import pc_pkg::*;
#(
  parameter int NUM_B1   = 6,
  parameter int NUM_BOTH = 8,
  parameter int NUM_B2   = 6,
  localparam int NUM_IN  = NUM_B1 + NUM_BOTH + NUM_B2,
  localparam int W1      = NUM_B1 + NUM_BOTH,
  localparam int W2      = NUM_BOTH + NUM_B2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] permitA,
  input  logic [NUM_IN-1:0] permitB,
  input  logic [NUM_IN-1:0] maskCfg,
  input  logic              safeFlagA,
  input  logic              safeFlagB,
  output logic              beam1Permit,
  output logic              beam2Permit,
  output logic [W1-1:0]     stateA1,
  output logic [W1-1:0]     stateB1,
  output logic [W2-1:0]     stateA2,
  output logic [W2-1:0]     stateB2
);
  ctlStrobe_t ctl;
  logic [1:0] ok1, ok2;
  logic [1:0][NUM_IN-1:0] pathIn;
  logic [1:0][W1-1:0] st1;
  logic [1:0][W2-1:0] st2;

  pc_ctrl u_ctrl (.safeFlagA(safeFlagA), .safeFlagB(safeFlagB), .strobe(ctl));

  assign pathIn[0] = permitA;
  assign pathIn[1] = permitB;

  // Two identical, separate paths: index 0 = A, index 1 = B
  for (genvar p = 0; p < 2; p++) begin : g_path
    pc_path #(.NUM_B1(NUM_B1), .NUM_BOTH(NUM_BOTH), .NUM_B2(NUM_B2)) u_path (
      .clk(clk), .rstN(rstN), .perm(pathIn[p]), .maskCfg(maskCfg),
      .strobe(ctl), .okBeam1(ok1[p]), .okBeam2(ok2[p]),
      .state1(st1[p]), .state2(st2[p]));
  end

  assign beam1Permit = ok1[0] & ok1[1];
  assign beam2Permit = ok2[0] & ok2[1];
  assign stateA1 = st1[0];
  assign stateB1 = st1[1];
  assign stateA2 = st2[0];
  assign stateB2 = st2[1];

  // R2: a granted beam with masking off shows all its users permitting
  a_r2_full_permit: assert property (@(posedge clk) disable iff (!rstN)
    (beam1Permit && $past(!ctl.maskOn)) |-> (&stateA1 && &stateB1));

  // R5: beam 2 is granted whenever its own users all permit
  a_r5_beam2_isolated: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(&permitA[NUM_IN-1:NUM_B1]) && $past(&permitB[NUM_IN-1:NUM_B1]))
      |-> beam2Permit);
endmodule

// File: tb/permit_combiner_test.sv
module permit_combiner_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  // Layout: [63:44] A, [43:24] B, [23:4] mask, [3] safeA, [2] safeB, [1] exp beam1, [0] exp beam2
  localparam logic [63:0] VECS [NV] = '{
    {20'hFFFFF, 20'hFFFFF, 20'h00000, 2'b00, 2'b11},  // R2 all permit
    {20'hFFFFE, 20'hFFFFF, 20'h00000, 2'b00, 2'b01},  // R3 R5 A[0] low
    {20'hFFFFF, 20'h7FFFF, 20'h00000, 2'b00, 2'b10},  // R3 R5 B[19] low
    {20'hFFDFF, 20'hFFFFF, 20'h00000, 2'b00, 2'b00},  // R4 A[9] low
    {20'hFFFFF, 20'hFFFBF, 20'h00000, 2'b11, 2'b00},  // R4 B[6] low, no mask
    {20'hFFFFB, 20'hFFFFF, 20'h00004, 2'b11, 2'b11},  // R6 A[2] masked
    {20'hFFFFB, 20'hFFFFF, 20'h00004, 2'b10, 2'b01},  // R7 flag disagree
    {20'hFFFFB, 20'hFFFFF, 20'h00004, 2'b01, 2'b01},  // R7 flag disagree
    {20'hFFBFF, 20'hFFFFF, 20'h00400, 2'b11, 2'b11},  // R6 A[10] masked
    {20'hFFBFF, 20'hFFFFF, 20'h00400, 2'b00, 2'b00},  // R7 both unsafe
    {20'hF7FFF, 20'hFFFFF, 20'h10000, 2'b11, 2'b10},  // R6 mask on neighbour only
    {20'h00000, 20'h00000, 20'hFFFFF, 2'b11, 2'b11}   // R6 all masked
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [19:0] permitA = '1, permitB = '1, maskCfg = '0;
  logic safeFlagA = 1'b0, safeFlagB = 1'b0;
  logic beam1Permit, beam2Permit;
  logic [13:0] stateA1, stateB1, stateA2, stateB2;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  permit_combiner uut (
    .clk(clk), .rstN(rstN), .permitA(permitA), .permitB(permitB),
    .maskCfg(maskCfg), .safeFlagA(safeFlagA), .safeFlagB(safeFlagB),
    .beam1Permit(beam1Permit), .beam2Permit(beam2Permit),
    .stateA1(stateA1), .stateB1(stateB1), .stateA2(stateA2), .stateB2(stateB2));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkStates(input string req, input logic [19:0] a, input logic [19:0] b);
    check(req, {stateA1, stateB1}, {a[13:0], b[13:0]});
    check(req, {stateA2, stateB2}, {a[19:6], b[19:6]});
  endtask

  initial begin
    #(CLK_PERIOD*50000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset values with all inputs permitting
    repeat (3) @(negedge clk);
    check("R1", {beam1Permit, beam2Permit}, 2'b00);
    check("R1", {stateA1, stateB1, stateA2, stateB2}, 56'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R2", {beam1Permit, beam2Permit}, 2'b11);
    checkStates("R8", 20'hFFFFF, 20'hFFFFF);

    for (int i = 0; i < NV; i++) begin
      permitA = VECS[i][63:44];
      permitB = VECS[i][43:24];
      maskCfg = VECS[i][23:4];
      safeFlagA = VECS[i][3];
      safeFlagB = VECS[i][2];
      @(negedge clk);
      check($sformatf("R2-R7 vector %0d", i), {beam1Permit, beam2Permit}, VECS[i][1:0]);
      checkStates("R8", VECS[i][63:44], VECS[i][43:24]);
    end

    // R3: withdrawal is visible after exactly one edge
    permitA = '1; permitB = '1; maskCfg = '0; safeFlagA = 0; safeFlagB = 0;
    @(negedge clk);
    check("R2", {beam1Permit, beam2Permit}, 2'b11);
    permitB = 20'hFFFDF;  // B[5] low
    #1;
    check("R3 before edge", {beam1Permit, beam2Permit}, 2'b11);
    @(negedge clk);
    check("R3", {beam1Permit, beam2Permit}, 2'b01);
    permitB = '1;
    @(negedge clk);
    check("R3 restore", {beam1Permit, beam2Permit}, 2'b11);

    // R8: distinct bit pattern across the state vectors
    permitA = 20'hA5C3F; permitB = 20'h3C96A;
    @(negedge clk);
    checkStates("R8 pattern", 20'hA5C3F, 20'h3C96A);

    // R1: reset mid-run clears everything
    permitA = '1; permitB = '1;
    rstN = 1'b0;
    @(negedge clk);
    check("R1 mid-run", {beam1Permit, beam2Permit}, 2'b00);
    check("R1 mid-run", {stateA1, stateB1, stateA2, stateB2}, 56'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 after reset", {beam1Permit, beam2Permit}, 2'b11);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule